// File: doc/BRIEF.md
# Page Write Buffer with Upper-Half Write Lock

This block sits between a serial-bus protocol engine and a 256-byte storage array. The protocol engine opens a write transaction with a byte address and then hands over data bytes one at a time. The bytes are held in a page buffer of 8 or 16 entries. Pages are aligned to the page size. Within a transaction only the low address bits advance, so a long burst wraps back to the start of its page, and later bytes replace earlier ones.

Nothing reaches the array until the protocol engine reports a stop. A stop that follows at least one data byte launches a timed programming cycle. During that cycle the buffered bytes are copied into the array, and a busy flag tells the protocol engine to withhold acknowledges. Any address with its top bit set belongs to a permanently locked half of the array and is never programmed. That half can still be read like any other address.

A read pointer serves current-address reads. Opening a transaction loads the pointer. After a programming cycle the pointer sits one past the last byte received, and each read advance moves it up by one across the whole array.

Top module: `page_write_buffer`

## Requirements
- R1: After reset, busy is low, the read pointer is 0, and every address a reads back as a XOR 8'h3C.
- R2: An open loads the read pointer with the open address, the read data always shows the array byte at the pointer, and each read advance adds 1 to the pointer modulo 256, crossing page boundaries freely.
- R3: The k-th data byte (k from 0) of a transaction opened at address A goes to the address whose upper bits are those of A and whose low log2(PAGE_BYTES) bits are (A + k) modulo PAGE_BYTES.
- R4: When more than PAGE_BYTES bytes arrive before the stop, each page slot ends up holding the last byte received for it.
- R5: A stop that follows at least one data byte raises busy at the clock edge that samples the stop. Busy then stays high for exactly WRITE_CYCLES cycles, and no other event raises it.
- R6: A stop with no data byte since the open starts no write cycle: busy stays low and the array is unchanged.
- R7: Only the page slots that received a byte are written; every other address keeps its contents.
- R8: Addresses 8'h80 to 8'hFF are never written. A transaction aimed there still runs its busy cycle, and the locked bytes keep their reset pattern.
- R9: While busy is high, opens, data bytes, stops and read advances have no effect on the pointer or on the array.
- R10: When a write cycle ends, the read pointer equals the address of the last received byte plus 1, modulo 256.
- R11: A second open without a stop in between discards the bytes buffered so far; they are never written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_open_i | input | 1 | Open a write transaction at wr_addr_i |
| wr_addr_i | input | 8 | Start address of the transaction |
| wr_byte_valid_i | input | 1 | A data byte is offered on wr_byte_i |
| wr_byte_i | input | 8 | Data byte |
| stop_i | input | 1 | Stop condition seen on the bus |
| rd_advance_i | input | 1 | Move the read pointer up by one |
| busy_o | output | 1 | Programming cycle in progress |
| rd_ptr_o | output | 8 | Current read pointer |
| rd_data_o | output | 8 | Array byte at the read pointer |

## Verification
A wrong slot index or a stale valid mask does not show during the transaction. It only appears after busy falls, when the page is read back, so the bench reads the whole array after every transaction and compares it with a model. A wrong programming timer shows within one cycle as a busy pulse of the wrong length. A pointer update on the wrong event shows immediately on rd_ptr_o once the cycle ends. Writes that reach the locked half, or that land on a neighbouring page, show as a mismatch on a byte the transaction should never have touched.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;
    localparam int DEPTH  = 1 << ADDR_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] byte_t;

    typedef enum logic [1:0] {
        PW_IDLE = 2'd0,
        PW_FILL = 2'd1,
        PW_PROG = 2'd2
    } pw_state_e;

    typedef struct packed {
        logic  en;
        addr_t addr;
        byte_t data;
    } arr_wr_t;

    function automatic logic in_locked_half(addr_t a);
        return a[ADDR_W-1];
    endfunction

    function automatic byte_t power_on_byte(addr_t a, byte_t seed);
        return byte_t'(a) ^ seed;
    endfunction
endpackage

// File: rtl/pwb_collect.sv
module pwb_collect
    import pwb_pkg::*;
#(
    parameter int PAGE_BYTES = 8
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               open_i,
    input  addr_t                              start_addr_i,
    input  logic                               take_i,
    input  byte_t                              data_i,
    output logic [PAGE_BYTES-1:0][DATA_W-1:0]  slots_o,
    output logic [PAGE_BYTES-1:0]              mask_o,
    output addr_t                              base_o,
    output addr_t                              last_o
);
    localparam int SLOT_W = $clog2(PAGE_BYTES);
    localparam addr_t LOW_MASK = addr_t'(PAGE_BYTES - 1);

    logic [SLOT_W-1:0] slot_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            slots_o <= '0;
            mask_o  <= '0;
            slot_q  <= '0;
            base_o  <= '0;
            last_o  <= '0;
        end else if (open_i) begin
            mask_o <= '0;
            slot_q <= start_addr_i[SLOT_W-1:0];
            base_o <= start_addr_i & ~LOW_MASK;
            last_o <= start_addr_i;
        end else if (take_i) begin
            slots_o[slot_q] <= data_i;
            mask_o[slot_q]  <= 1'b1;
            last_o          <= base_o | addr_t'(slot_q);
            slot_q          <= slot_q + 1'b1;
        end
    end

    // R3
    slot_in_page_chk: assert property (@(posedge clk) disable iff (rst)
        take_i && !open_i |=> (last_o & ~LOW_MASK) == base_o);
endmodule

// File: rtl/pwb_commit.sv
module pwb_commit
    import pwb_pkg::*;
#(
    parameter int PAGE_BYTES   = 8,
    parameter int WRITE_CYCLES = 40
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               start_i,
    input  logic                               byte_i,
    input  logic                               stop_i,
    input  logic [PAGE_BYTES-1:0]              mask_i,
    input  logic [PAGE_BYTES-1:0][DATA_W-1:0]  slots_i,
    input  addr_t                              base_i,
    output logic                               busy_o,
    output logic                               open_o,
    output logic                               take_o,
    output logic                               launch_o,
    output arr_wr_t                            wr_o
);
    localparam int SLOT_W = $clog2(PAGE_BYTES);
    localparam int CNT_W  = $clog2(WRITE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WRITE_CYCLES - 1);

    pw_state_e         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [SLOT_W-1:0] slot;

    assign busy_o   = (state_q == PW_PROG);
    assign open_o   = !busy_o && start_i;
    assign take_o   = (state_q == PW_FILL) && byte_i && !start_i;
    assign launch_o = (state_q == PW_FILL) && !start_i && stop_i && (|mask_i);

    always_comb begin
        state_d = state_q;
        case (state_q)
            PW_IDLE: if (start_i) state_d = PW_FILL;
            PW_FILL: begin
                if (start_i)     state_d = PW_FILL;
                else if (stop_i) state_d = (|mask_i) ? PW_PROG : PW_IDLE;
            end
            PW_PROG: if (cnt_q == CNT_LAST) state_d = PW_IDLE;
            default: state_d = PW_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PW_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (launch_o)     cnt_q <= '0;
            else if (busy_o)  cnt_q <= cnt_q + 1'b1;
        end
    end

    assign slot = cnt_q[SLOT_W-1:0];

    always_comb begin
        wr_o.en   = busy_o && (32'(cnt_q) < PAGE_BYTES) && mask_i[slot]
                    && !in_locked_half(base_i);
        wr_o.addr = base_i | addr_t'(slot);
        wr_o.data = slots_i[slot];
    end

    // R5
    launch_by_stop_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(stop_i));
    // R6
    empty_stop_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == PW_FILL) && stop_i && !start_i && (mask_i == '0) |=> !busy_o);
    // R5
    busy_window_chk: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> 32'(cnt_q) < WRITE_CYCLES);
endmodule

// File: rtl/pwb_array.sv
module pwb_array
    import pwb_pkg::*;
#(
    parameter byte_t INIT_SEED = 8'h3C
) (
    input  logic    clk,
    input  logic    rst,
    input  arr_wr_t wr_i,
    input  addr_t   rd_addr_i,
    output byte_t   rd_data_o
);
    byte_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= power_on_byte(addr_t'(i), INIT_SEED);
        end else if (wr_i.en) begin
            mem[wr_i.addr] <= wr_i.data;
        end
    end

    assign rd_data_o = mem[rd_addr_i];

    // R8
    locked_half_chk: assert property (@(posedge clk) disable iff (rst)
        wr_i.en |-> !in_locked_half(wr_i.addr));
endmodule

// File: rtl/page_write_buffer.sv
module page_write_buffer
    import pwb_pkg::*;
#(
    parameter int    PAGE_BYTES   = 8,
    parameter int    WRITE_CYCLES = 40,
    parameter byte_t INIT_SEED    = 8'h3C
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_open_i,
    input  logic [7:0] wr_addr_i,
    input  logic       wr_byte_valid_i,
    input  logic [7:0] wr_byte_i,
    input  logic       stop_i,
    input  logic       rd_advance_i,
    output logic       busy_o,
    output logic [7:0] rd_ptr_o,
    output logic [7:0] rd_data_o
);
    logic [PAGE_BYTES-1:0][DATA_W-1:0] slots;
    logic [PAGE_BYTES-1:0]             mask;
    addr_t                             base, last;
    logic                              open, take, launch;
    arr_wr_t                           wr;
    addr_t                             rptr_q;

    pwb_collect #(.PAGE_BYTES(PAGE_BYTES)) u_collect (
        .clk(clk), .rst(rst),
        .open_i(open), .start_addr_i(wr_addr_i),
        .take_i(take), .data_i(wr_byte_i),
        .slots_o(slots), .mask_o(mask), .base_o(base), .last_o(last)
    );

    pwb_commit #(.PAGE_BYTES(PAGE_BYTES), .WRITE_CYCLES(WRITE_CYCLES)) u_commit (
        .clk(clk), .rst(rst),
        .start_i(wr_open_i), .byte_i(wr_byte_valid_i), .stop_i(stop_i),
        .mask_i(mask), .slots_i(slots), .base_i(base),
        .busy_o(busy_o), .open_o(open), .take_o(take), .launch_o(launch),
        .wr_o(wr)
    );

    pwb_array #(.INIT_SEED(INIT_SEED)) u_array (
        .clk(clk), .rst(rst),
        .wr_i(wr), .rd_addr_i(rptr_q), .rd_data_o(rd_data_o)
    );

    always_ff @(posedge clk) begin
        if (rst)                          rptr_q <= '0;
        else if (open)                    rptr_q <= wr_addr_i;
        else if (launch)                  rptr_q <= last + 1'b1;
        else if (rd_advance_i && !busy_o) rptr_q <= rptr_q + 1'b1;
    end

    assign rd_ptr_o = rptr_q;

    // R9
    ptr_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> $stable(rptr_q));
endmodule

// File: tb/sim_page_write_buffer.sv
module sim_page_write_buffer;
    localparam int CLK_PERIOD = 10;
    localparam int PB   = 8;
    localparam int WC   = 40;
    localparam logic [7:0] SEED = 8'h3C;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_open = 1'b0, wr_valid = 1'b0, stop = 1'b0, rd_adv = 1'b0;
    logic [7:0] wr_addr = '0, wr_byte = '0;
    logic busy;
    logic [7:0] rd_ptr, rd_data;

    int n_run = 0, n_fail = 0;
    logic [7:0] model [256];

    always #(CLK_PERIOD/2) clk = ~clk;

    page_write_buffer #(.PAGE_BYTES(PB), .WRITE_CYCLES(WC), .INIT_SEED(SEED)) u0 (
        .clk(clk), .rst(rst), .wr_open_i(wr_open), .wr_addr_i(wr_addr),
        .wr_byte_valid_i(wr_valid), .wr_byte_i(wr_byte), .stop_i(stop),
        .rd_advance_i(rd_adv), .busy_o(busy), .rd_ptr_o(rd_ptr), .rd_data_o(rd_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_open(input logic [7:0] a);
        wr_open = 1'b1; wr_addr = a;
        @(negedge clk); wr_open = 1'b0;
    endtask

    task automatic do_byte(input logic [7:0] b);
        wr_valid = 1'b1; wr_byte = b;
        @(negedge clk); wr_valid = 1'b0;
    endtask

    task automatic do_stop();
        stop = 1'b1;
        @(negedge clk); stop = 1'b0;
    endtask

    task automatic wait_idle(output int len);
        len = 0;
        while (busy && len < 1000) begin
            len++;
            @(negedge clk);
        end
    endtask

    // Sets pointer to 0 with an empty transaction, then reads all 256 bytes.
    task automatic scan(input string req);
        int bad = 0, bad_a = 0, bad_v = 0;
        do_open(8'h00);
        do_stop();
        for (int i = 0; i < 256; i++) begin
            if (rd_data !== model[i] || rd_ptr !== 8'(i)) begin
                if (bad == 0) begin bad_a = i; bad_v = rd_data; end
                bad++;
            end
            rd_adv = 1'b1;
            @(negedge clk);
        end
        rd_adv = 1'b0;
        chk(bad == 0, req, bad_v, model[bad_a]);
        // R2: pointer wraps modulo 256
        chk(rd_ptr == 8'h00, "R2", rd_ptr, 0);
    endtask

    task automatic write_trial(input int page, input int off, input int cnt,
                               input int salt, input string req);
        logic [7:0] a, b, exp_ptr;
        int len;
        a = 8'(page * PB + off);
        do_open(a);
        for (int k = 0; k < cnt; k++) begin
            b = 8'(salt + k * 7 + 1);
            if (page * PB < 128) model[page * PB + ((off + k) % PB)] = b;
            do_byte(b);
        end
        do_stop();
        if (cnt > 0) begin
            chk(busy == 1'b1, "R5", busy, 1);
            wait_idle(len);
            chk(len == WC, "R5", len, WC);
            exp_ptr = 8'(page * PB + ((off + cnt - 1) % PB) + 1);
            chk(rd_ptr == exp_ptr, "R10", rd_ptr, exp_ptr);
        end else begin
            chk(busy == 1'b0, "R6", busy, 0);
            chk(rd_ptr == a, "R2", rd_ptr, a);
        end
        scan(req);
    endtask

    initial begin
        int len;
        for (int i = 0; i < 256; i++) model[i] = 8'(i) ^ SEED;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk(busy == 1'b0, "R1", busy, 0);
        chk(rd_ptr == 8'h00, "R1", rd_ptr, 0);
        scan("R1");

        // R3 R4 R7: every start slot and burst lengths past one page
        for (int off = 0; off < PB; off++)
            for (int cnt = 0; cnt <= PB + 3; cnt++)
                write_trial((off * 3 + cnt) % 16, off, cnt, off * 16 + cnt,
                            cnt > PB ? "R4" : (cnt == 0 ? "R6" : "R3"));

        // R7: single byte into the middle of a page
        write_trial(5, 3, 1, 8'h90, "R7");

        // R8: locked half pages, including a wrapping burst
        write_trial(16, 0, 3, 8'h11, "R8");
        write_trial(31, 6, PB + 2, 8'h22, "R8");

        // R9: traffic while busy is ignored
        do_open(8'h40);
        do_byte(8'hA1); model[8'h40] = 8'hA1;
        do_stop();
        do_open(8'h10);
        do_byte(8'hEE);
        do_stop();
        rd_adv = 1'b1; @(negedge clk); rd_adv = 1'b0;
        wait_idle(len);
        chk(len == WC - 4, "R9", len, WC - 4);
        chk(rd_ptr == 8'h41, "R9", rd_ptr, 8'h41);
        scan("R9");

        // R11: a reopen without stop drops the buffered bytes
        do_open(8'h20);
        do_byte(8'h55);
        do_byte(8'h66);
        do_open(8'h33);
        do_stop();
        chk(busy == 1'b0, "R11", busy, 0);
        chk(rd_ptr == 8'h33, "R11", rd_ptr, 8'h33);
        scan("R11");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule